// File: doc/BRIEF.md
# Multiplexed Bus Transfer Sequencer

This block is the requestor side of a 32-bit bus whose lines carry an address and then data. Time on the bus is divided into T periods. Each T period is two clock cycles: an address portion followed by a data portion. A local user presents a read or write of a byte, a 16-bit half or a full 32-bit word. When the bus is granted and free, the sequencer takes the request. In the next address portion it drives the address, the byte-lane enables and the direction. In the data portion it either drives the write data onto its lanes or samples the read data from them.

A single shared READY line, sampled at the end of each data portion, decides how a transfer ends. If the server holds READY low, the transfer stretches into the following T period. The address portion of that period is left undriven, and the data portion repeats until READY is seen high. The sequencer drives READY itself, always asserted, only during the data portion of an idle T period in which it owns the bus. It never drives READY during an address portion or while a server is answering. The block returns a one-cycle done pulse, together with the read data aligned to bit 0, in the data portion where READY is high.

Top module: `bus_xfer_seq`

## Requirements
- R1: While `rst_n` is low, the sequencer is idle and `bus_ad_oe`, `bus_rdy_oe`, `req_accept` and `usr_done` are all low.
- R2: After reset the cycles alternate between address portion and data portion, starting with an address portion. `bus_rdy_oe` is never high in an address portion.
- R3: `req_accept` is high in a cycle only when all of these hold: the cycle is a data portion, the sequencer is idle, `req_valid` and `bus_grant` are high, `bus_rdy_i` is high, and the request is legal. The request is captured at that clock edge.
- R4: In the address portion that follows an accept, `bus_ad_oe` is high, `bus_ad_o` carries the full request address and `bus_wr_o` carries the write flag (1 = write).
- R5: In each data portion of a write, `bus_ad_oe` is high and `bus_ad_o` equals the write data, masked to the transfer size and shifted left by 8 times the low two address bits. In the data portion of a read, `bus_ad_oe` is low.
- R6: When `bus_rdy_i` is low at the end of a transfer's data portion, the next address portion drives nothing (`bus_ad_oe` and `bus_rdy_oe` low) and the data portion repeats. After the final data portion the next address portion is also undriven.
- R7: `usr_done` is high for exactly the one data-portion cycle in which `bus_rdy_i` is high during a transfer. For a read, `usr_rdata` in that cycle equals the bus data shifted right by 8 times the low two address bits and masked to the size.
- R8: `bus_lane_o` bit i is high when byte i is part of the transfer. The transfer covers 1, 2 or 4 bytes starting at the byte numbered by the low two address bits.
- R9: The `req_size` encoding is 0 = byte, 1 = half, 2 = word, and 3 is illegal. A half needs address bit 0 clear, and a word needs address bits 1:0 clear. An illegal request is never accepted and leaves the bus undriven.
- R10: In the data portion of an idle T period, `bus_rdy_oe` equals `bus_grant`, with `bus_rdy_o` high. During a transfer `bus_rdy_oe` stays low.
- R11: If `bus_rdy_i` is low in an idle data portion, no request is accepted even when one is granted, and the following address portion stays undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 illegal |
| req_addr | input | DW | Request address |
| req_wdata | input | DW | Write data, right-justified |
| req_accept | output | 1 | Request taken this cycle |
| usr_done | output | 1 | Transfer completed this cycle |
| usr_rdata | output | DW | Read data, right-justified, valid with usr_done |
| bus_grant | input | 1 | Arbitration grant for this requestor |
| bus_ad_o | output | DW | Address/data lines, outgoing value |
| bus_ad_i | input | DW | Address/data lines, resolved value |
| bus_ad_oe | output | 1 | Drive enable for address/data lines |
| bus_lane_o | output | DW/8 | Byte-lane enables, valid while bus_ad_oe |
| bus_wr_o | output | 1 | Direction, valid while bus_ad_oe |
| bus_rdy_i | input | 1 | Resolved READY line |
| bus_rdy_o | output | 1 | READY value when driven (always asserted) |
| bus_rdy_oe | output | 1 | Drive enable for READY |

## Verification
On every cycle, the bound checker enforces several rules. READY is never driven in an address portion, or while the sequencer is in a transfer's data phase. An accept only happens under its enabling inputs, and the address it took appears on the lines one cycle later. A stalled data portion leaves the next address portion empty and keeps the transfer open. The done pulse never lasts two cycles. Lane steering, read-data extraction, alignment legality and the exact cycle of done under one or more wait periods depend on the data values. These are shown only by the bench's sweep over every legal size, offset, direction and wait count, plus the directed refusals.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_FULL = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  // Alignment rule: byte anywhere, half on even byte, full word on offset zero.
  function automatic logic size_legal(input logic [1:0] sz, input logic [7:0] off);
    logic ok;
    case (sz)
      SZ_BYTE: ok = 1'b1;
      SZ_HALF: ok = (off[0] == 1'b0);
      SZ_FULL: ok = (off == 8'd0);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/bus_xfer_phase.sv
// Tracks which half of the T period the current cycle belongs to.
module bus_xfer_phase (
  input  logic clk,
  input  logic rst_n,
  output logic data_ph
);

  logic ph_q, ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign data_ph = ph_q;

endmodule

// File: rtl/bus_xfer_steer.sv
// Byte-lane selection, write-data placement and read-data extraction.
module bus_xfer_steer #(
  parameter int DW = 32
) (
  input  logic [1:0]              size,
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           ad_in,
  output logic [DW/8-1:0]         lanes,
  output logic [DW-1:0]           wplaced,
  output logic [DW-1:0]           rextract
);

  localparam int LN = DW / 8;
  localparam int OB = $clog2(LN);

  logic [OB:0]   nbytes;
  logic [DW-1:0] mask;

  always_comb begin
    case (size)
      2'd0:    nbytes = (OB+1)'(1);
      2'd1:    nbytes = (OB+1)'(2);
      default: nbytes = (OB+1)'(LN);
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < LN; gi++) begin : g_lane
      assign lanes[gi] = ((OB+1)'(gi) >= {1'b0, off}) &&
                         ((OB+1)'(gi) <  ({1'b0, off} + nbytes));
      assign mask[8*gi +: 8] = ((OB+1)'(gi) < nbytes) ? 8'hFF : 8'h00;
    end
  endgenerate

  always_comb begin
    wplaced  = (wdata & mask) << (8 * off);
    rextract = (ad_in >> (8 * off)) & mask;
  end

endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq #(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_accept,
  output logic              usr_done,
  output logic [DW-1:0]     usr_rdata,
  input  logic              bus_grant,
  output logic [DW-1:0]     bus_ad_o,
  input  logic [DW-1:0]     bus_ad_i,
  output logic              bus_ad_oe,
  output logic [DW/8-1:0]   bus_lane_o,
  output logic              bus_wr_o,
  input  logic              bus_rdy_i,
  output logic              bus_rdy_o,
  output logic              bus_rdy_oe
);

  import bus_xfer_pkg::*;

  localparam int LN = DW / 8;
  localparam int OB = $clog2(LN);

  logic          ph;
  seq_state_e    st_q, st_d;
  logic [DW-1:0] addr_q, wdata_q;
  logic [1:0]    size_q;
  logic          wr_q;
  logic          cap_en;
  logic          req_legal;
  logic          in_idle, in_addr, in_data;
  logic [LN-1:0] lanes;
  logic [DW-1:0] wplaced, rextract;

  bus_xfer_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_ph (ph)
  );

  bus_xfer_steer #(.DW(DW)) u_steer (
    .size     (size_q),
    .off      (addr_q[OB-1:0]),
    .wdata    (wdata_q),
    .ad_in    (bus_ad_i),
    .lanes    (lanes),
    .wplaced  (wplaced),
    .rextract (rextract)
  );

  assign in_idle   = (st_q == ST_IDLE);
  assign in_addr   = (st_q == ST_ADDR);
  assign in_data   = (st_q == ST_DATA);
  assign req_legal = size_legal(req_size, 8'(req_addr[OB-1:0]));

  // A new address may only follow a data portion that ended with READY high.
  assign req_accept = ph && in_idle && req_valid && bus_grant && bus_rdy_i && req_legal;
  assign cap_en     = req_accept;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_accept)     st_d = ST_ADDR;
      ST_ADDR:                     st_d = ST_DATA;
      ST_DATA: if (ph && bus_rdy_i) st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      size_q  <= req_size;
      wr_q    <= req_write;
    end
  end

  // Extended address portions (data state, ph low) drive nothing.
  assign bus_ad_oe  = in_addr || (in_data && ph && wr_q);
  assign bus_ad_o   = in_addr ? addr_q : wplaced;
  assign bus_lane_o = lanes;
  assign bus_wr_o   = wr_q;

  // Owner holds READY high during idle data portions; servers own it in transfers.
  assign bus_rdy_oe = ph && in_idle && bus_grant;
  assign bus_rdy_o  = 1'b1;

  assign usr_done  = in_data && ph && bus_rdy_i;
  assign usr_rdata = rextract;

endmodule

// File: rtl/bus_xfer_seq_chk.sv
module bus_xfer_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph,
  input logic          in_data,
  input logic          req_valid,
  input logic          req_write,
  input logic [DW-1:0] req_addr,
  input logic          req_accept,
  input logic          usr_done,
  input logic          bus_grant,
  input logic [DW-1:0] bus_ad_o,
  input logic          bus_ad_oe,
  input logic          bus_wr_o,
  input logic          bus_rdy_i,
  input logic          bus_rdy_oe
);

  assert_rdy_hiz_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ph |-> !bus_rdy_oe);

  assert_accept_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (ph && req_valid && bus_grant && bus_rdy_i));

  assert_addr_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (bus_ad_oe && !ph && bus_ad_o == $past(req_addr) && bus_wr_o == $past(req_write)));

  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph && in_data && !bus_rdy_i) |=> (!bus_ad_oe && !bus_rdy_oe && in_data));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |=> !usr_done);

  assert_server_owns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> !bus_rdy_oe);

endmodule

bind bus_xfer_seq bus_xfer_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph         (ph),
  .in_data    (in_data),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_accept (req_accept),
  .usr_done   (usr_done),
  .bus_grant  (bus_grant),
  .bus_ad_o   (bus_ad_o),
  .bus_ad_oe  (bus_ad_oe),
  .bus_wr_o   (bus_wr_o),
  .bus_rdy_i  (bus_rdy_i),
  .bus_rdy_oe (bus_rdy_oe)
);

// File: tb/bus_xfer_seq_test.sv
module bus_xfer_seq_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_size;
  logic [DW-1:0] req_addr, req_wdata;
  logic          req_accept, usr_done;
  logic [DW-1:0] usr_rdata;
  logic          bus_grant;
  logic [DW-1:0] bus_ad_o, bus_ad_i;
  logic          bus_ad_oe;
  logic [3:0]    bus_lane_o;
  logic          bus_wr_o, bus_rdy_i, bus_rdy_o, bus_rdy_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic tph;

  bus_xfer_seq #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_accept(req_accept), .usr_done(usr_done), .usr_rdata(usr_rdata),
    .bus_grant(bus_grant), .bus_ad_o(bus_ad_o), .bus_ad_i(bus_ad_i),
    .bus_ad_oe(bus_ad_oe), .bus_lane_o(bus_lane_o), .bus_wr_o(bus_wr_o),
    .bus_rdy_i(bus_rdy_i), .bus_rdy_o(bus_rdy_o), .bus_rdy_oe(bus_rdy_oe)
  );

  always #4 clk = ~clk;

  // Bench view of the T-period half: address portion first after reset.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tph <= 1'b0;
    else        tph <= ~tph;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic to_data_portion();
    @(negedge clk);
    if (tph == 1'b0) @(negedge clk);
  endtask

  task automatic do_xfer(input logic wr, input int sz, input int off, input int waits);
    logic [31:0] a, wd, rp, mask;
    int sh, nb;
    logic [3:0] lexp;
    a    = 32'h3C00_0000 | (sz << 8) | (waits << 12) | off;
    wd   = 32'hC3A5_96E1 + off * 32'h0101_0101 + sz;
    rp   = 32'h5A69_F00F ^ (waits * 32'h1111_0000) ^ off;
    mask = (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    sh   = off * 8;
    lexp = 4'(((1 << nb) - 1) << off);
    to_data_portion();
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
    req_addr = a; req_wdata = wd; bus_grant = 1'b1; bus_rdy_i = 1'b1;
    #1;
    chk("R3 accept legal granted", 32'(req_accept), 32'd1);
    chk("R10 owner drives ready idle", 32'(bus_rdy_oe), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R4 addr oe", 32'(bus_ad_oe), 32'd1);
    chk("R4 addr value", bus_ad_o, a);
    chk("R4 direction", 32'(bus_wr_o), 32'(wr));
    chk("R8 lanes", 32'(bus_lane_o), 32'(lexp));
    chk("R2 ready hiz in addr", 32'(bus_rdy_oe), 32'd0);
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);
      bus_rdy_i = (k == waits);
      bus_ad_i  = rp;
      #1;
      if (wr) begin
        chk("R5 write oe", 32'(bus_ad_oe), 32'd1);
        chk("R5 write data", bus_ad_o, (wd & mask) << sh);
      end else begin
        chk("R5 read oe off", 32'(bus_ad_oe), 32'd0);
      end
      chk("R7 done timing", 32'(usr_done), 32'(k == waits));
      if (!wr && k == waits) chk("R7 read data", usr_rdata, (rp >> sh) & mask);
      chk("R10 server owns ready", 32'(bus_rdy_oe), 32'd0);
      if (k < waits) begin
        @(negedge clk);
        #1;
        chk("R6 stall addr oe", 32'(bus_ad_oe), 32'd0);
        chk("R6 stall ready oe", 32'(bus_rdy_oe), 32'd0);
        chk("R6 stall no done", 32'(usr_done), 32'd0);
      end
    end
    bus_rdy_i = 1'b1;
    @(negedge clk);
    #1;
    chk("R6 after done undriven", 32'(bus_ad_oe), 32'd0);
  endtask

  task automatic try_refused(input string tag, input int sz, input int off,
                             input logic gnt, input logic rdy);
    to_data_portion();
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'(sz);
    req_addr = 32'h0F00_0000 | off; req_wdata = 32'hFFFF_FFFF;
    bus_grant = gnt; bus_rdy_i = rdy;
    #1;
    chk({tag, " no accept"}, 32'(req_accept), 32'd0);
    if (!gnt) chk("R10 no ready drive without grant", 32'(bus_rdy_oe), 32'd0);
    @(negedge clk);
    #1;
    chk({tag, " bus undriven"}, 32'(bus_ad_oe), 32'd0);
    chk("R2 ready hiz in addr", 32'(bus_rdy_oe), 32'd0);
    req_valid = 1'b0; bus_grant = 1'b1; bus_rdy_i = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; bus_grant = 1'b1; bus_ad_i = '0; bus_rdy_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset ad oe", 32'(bus_ad_oe), 32'd0);
    chk("R1 reset ready oe", 32'(bus_rdy_oe), 32'd0);
    chk("R1 reset done", 32'(usr_done), 32'd0);
    chk("R1 reset accept", 32'(req_accept), 32'd0);
    rst_n = 1'b1;

    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int waits = 0; waits < 3; waits++)
            if (sz == 0 || (sz == 1 && off[0] == 1'b0) || (sz == 2 && off == 0))
              do_xfer(w[0], sz, off, waits);

    try_refused("R9 half odd", 1, 1, 1'b1, 1'b1);
    try_refused("R9 half odd high", 1, 3, 1'b1, 1'b1);
    try_refused("R9 word offset 2", 2, 2, 1'b1, 1'b1);
    try_refused("R9 size 3", 3, 0, 1'b1, 1'b1);
    try_refused("R3 no grant", 2, 0, 1'b0, 1'b1);
    try_refused("R11 ready low idle", 0, 1, 1'b1, 1'b0);

    do_xfer(1'b0, 0, 3, 1);

    summary();
    $finish;
  end

endmodule